// File: doc/BRIEF.md
# Cipher Command Queue Sequencer

This block sits between a host and a block-cipher datapath. The host pushes 32-bit command words into a small inbound queue. A decoder pulls them out one at a time and reads the opcode and fields. It then drives request lines toward three neighbours: a memory-copy unit, a key-table loader and the cipher engine. It waits for each neighbour's acknowledge before it takes the next command.

Two commands use two words. A copy command and a DMA-setup command each take the following queue word as an address. A block-start command carries its block count minus one. A DMA-complete command marks the end of a job and raises a completion interrupt.

The host polls three live flags: engine busy, queue empty and copy busy. Three sticky interrupt causes cover job completion, a bad opcode and a write to a full queue. Each cause is cleared by writing one to its clear bit, and each can be masked onto a single interrupt line.

Top module: `cmdq_seq_top`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1), `eng_busy`, `dma_busy` and every request output are 0, and `int_status` is 0.
- R2: The queue holds up to DEPTH (default 5) words and hands them to the decoder in write order. A write made while the queue holds DEPTH words is dropped and sets `int_status[2]` (overflow).
- R3: The opcode sits in bits [31:26]. A word whose opcode is not one of 0x0E, 0x10, 0x11, 0x21 or 0x23 is discarded, raises no request, and sets `int_status[1]`. A malformed table-load (see R5) is treated the same way.
- R4: Copy (opcode 0x21) reads its direction from bit 25 (0 = external memory into internal RAM, 1 = the reverse) and its word count from bits [24:12]. The next queue word is the external address. `cp_req` then stays high with `cp_dir`, `cp_words` and `cp_addr` stable until the cycle `cp_ack` is seen. `dma_busy` is high for that whole time.
- R5: Table-load (opcode 0x23) needs bits [25:24]=3 and bit 23=1. Bits [22:17] must equal 0x8 ORed with a 3-bit slot number. When the word is valid, `tbl_req` stays high with `tbl_slot` equal to that slot until `tbl_ack`.
- R6: DMA-setup (opcode 0x10) takes the next queue word as the source address and shows it on `eng_src_addr` for the block-starts that follow.
- R7: Block-start (opcode 0x0E) holds the block count minus one in bits [11:0]. `eng_req` stays high with `eng_blocks` equal to that field plus one until `eng_done`.
- R8: DMA-complete (opcode 0x11) sets `int_status[0]` once every earlier command has finished.
- R9: Commands run one at a time. `eng_busy` is high while any command is in progress, and the next word is not taken until the current handshake completes.
- R10: Each `int_status` bit is cleared by a one on the matching `int_clr` bit. A new event in the same cycle wins over the clear. `irq` is high exactly when some status bit has its `int_mask` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Host command write strobe |
| cmd_wr_data | input | 32 | Host command word |
| eng_busy | output | 1 | A command is in progress |
| q_empty | output | 1 | Inbound queue holds no words |
| dma_busy | output | 1 | A copy request is outstanding |
| cp_req | output | 1 | Copy request to memory-copy unit |
| cp_dir | output | 1 | Copy direction |
| cp_words | output | WCNT_W | Copy length in 32-bit words |
| cp_addr | output | ADDR_W | External address of the copy |
| cp_ack | input | 1 | Copy finished |
| tbl_req | output | 1 | Key-table load request |
| tbl_slot | output | 3 | Key slot to load |
| tbl_ack | input | 1 | Table load finished |
| eng_req | output | 1 | Cipher run request |
| eng_blocks | output | BLK_W+1 | Number of 16-byte blocks |
| eng_src_addr | output | ADDR_W | Source address from the last setup |
| eng_done | input | 1 | Cipher run finished |
| int_mask | input | 3 | Interrupt enable per cause |
| int_clr | input | 3 | Write-one-to-clear per cause |
| int_status | output | 3 | Sticky causes: 0 done, 1 bad opcode, 2 overflow |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: a queue depth of 5, a 12-bit block field and a 13-bit word count. A depth of five can be filled by hand while one block-start is held unacknowledged, so the drop of a sixth word and the strict order of the five queued words can both be observed at the ports. The wide count fields let random stimulus reach a block count of 4096 and the 16-word key-table copy, as well as small values.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int CMD_W   = 32;
    localparam int OPC_LSB = 26;
    localparam int OPC_W   = 6;
    localparam int DIR_BIT = 25;
    localparam int WCNT_LSB = 12;
    localparam int TSEL_LSB = 24;
    localparam int RSEL_BIT = 23;
    localparam int KID_LSB  = 17;
    localparam int KID_W    = 6;
    localparam int SLOT_W   = 3;

    localparam logic [OPC_W-1:0] OP_START = 6'h0E;
    localparam logic [OPC_W-1:0] OP_SETUP = 6'h10;
    localparam logic [OPC_W-1:0] OP_DONE  = 6'h11;
    localparam logic [OPC_W-1:0] OP_COPY  = 6'h21;
    localparam logic [OPC_W-1:0] OP_TABLE = 6'h23;

    localparam int IRQ_N    = 3;
    localparam int IRQ_DONE = 0;
    localparam int IRQ_BAD  = 1;
    localparam int IRQ_OVF  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_COPY,
        ST_TABLE,
        ST_RUN
    } seq_state_e;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         valid,
    output logic         empty,
    output logic         drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  full, acc_d, pop_ok_d;

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign valid = !empty;
    assign head  = s_q.mem[s_q.rp];
    assign drop  = wr_en && full;

    always_comb begin
        s_d      = s_q;
        acc_d    = wr_en && !full;
        pop_ok_d = pop && !empty;
        if (acc_d) begin
            s_d.mem[s_q.wp] = wr_data;
            s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
        end
        if (pop_ok_d) begin
            s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + CNT_W'(acc_d) - CNT_W'(pop_ok_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    assert_drop_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !pop) |=> (s_q.cnt == CNT_W'(DEPTH)));
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 12,
    parameter int WCNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [CMD_W-1:0]  head,
    output logic              pop,
    output logic              busy,
    output logic              cp_req,
    output logic              cp_dir,
    output logic [WCNT_W-1:0] cp_words,
    output logic [ADDR_W-1:0] cp_addr,
    input  logic              cp_ack,
    output logic              tbl_req,
    output logic [SLOT_W-1:0] tbl_slot,
    input  logic              tbl_ack,
    output logic              eng_req,
    output logic [BLK_W:0]    eng_blocks,
    output logic [ADDR_W-1:0] eng_src_addr,
    input  logic              eng_done,
    output logic              done_p,
    output logic              bad_p
);
    typedef struct packed {
        seq_state_e        state;
        logic              is_copy;
        logic              dir;
        logic [WCNT_W-1:0] words;
        logic [ADDR_W-1:0] addr;
        logic [SLOT_W-1:0] slot;
        logic [BLK_W:0]    blocks;
        logic [ADDR_W-1:0] src;
        logic              done_p;
        logic              bad_p;
    } dec_t;

    dec_t r_d, r_q;
    logic [OPC_W-1:0] opc;
    logic [KID_W-1:0] kid;
    logic             tbl_ok;

    assign opc    = head[OPC_LSB +: OPC_W];
    assign kid    = head[KID_LSB +: KID_W];
    assign tbl_ok = (head[TSEL_LSB +: 2] == 2'b11) && head[RSEL_BIT]
                  && (kid[KID_W-1:SLOT_W] == 3'b001);

    always_comb begin
        r_d        = r_q;
        r_d.done_p = 1'b0;
        r_d.bad_p  = 1'b0;
        pop        = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (head_valid) begin
                    pop = 1'b1;
                    case (opc)
                        OP_COPY: begin
                            r_d.is_copy = 1'b1;
                            r_d.dir     = head[DIR_BIT];
                            r_d.words   = head[WCNT_LSB +: WCNT_W];
                            r_d.state   = ST_ADDR;
                        end
                        OP_SETUP: begin
                            r_d.is_copy = 1'b0;
                            r_d.state   = ST_ADDR;
                        end
                        OP_TABLE: begin
                            if (tbl_ok) begin
                                r_d.slot  = kid[SLOT_W-1:0];
                                r_d.state = ST_TABLE;
                            end else begin
                                r_d.bad_p = 1'b1;
                            end
                        end
                        OP_START: begin
                            r_d.blocks = {1'b0, head[BLK_W-1:0]} + 1'b1;
                            r_d.state  = ST_RUN;
                        end
                        OP_DONE: r_d.done_p = 1'b1;
                        default: r_d.bad_p  = 1'b1;
                    endcase
                end
            end
            ST_ADDR: begin
                if (head_valid) begin
                    pop = 1'b1;
                    if (r_q.is_copy) begin
                        r_d.addr  = head[ADDR_W-1:0];
                        r_d.state = ST_COPY;
                    end else begin
                        r_d.src   = head[ADDR_W-1:0];
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_COPY:  if (cp_ack)   r_d.state = ST_IDLE;
            ST_TABLE: if (tbl_ack)  r_d.state = ST_IDLE;
            ST_RUN:   if (eng_done) r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign cp_req       = (r_q.state == ST_COPY);
    assign cp_dir       = r_q.dir;
    assign cp_words     = r_q.words;
    assign cp_addr      = r_q.addr;
    assign tbl_req      = (r_q.state == ST_TABLE);
    assign tbl_slot     = r_q.slot;
    assign eng_req      = (r_q.state == ST_RUN);
    assign eng_blocks   = r_q.blocks;
    assign eng_src_addr = r_q.src;
    assign done_p       = r_q.done_p;
    assign bad_p        = r_q.bad_p;

    assert_copy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_req && !cp_ack) |=> (cp_req && $stable(cp_addr) && $stable(cp_words) && $stable(cp_dir)));
    assert_table_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_slot)));
    assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_blocks)));
    assert_pop_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] st;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d.st = (i_q.st & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign status = i_q.st;
    assign irq    = |(i_q.st & mask);

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set[g]) |=> !status[g]);
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> status[g]);
    end
endmodule

// File: rtl/cmdq_seq_top.sv
module cmdq_seq_top
    import cmdq_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 12,
    parameter int WCNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [31:0]       cmd_wr_data,
    output logic              eng_busy,
    output logic              q_empty,
    output logic              dma_busy,
    output logic              cp_req,
    output logic              cp_dir,
    output logic [WCNT_W-1:0] cp_words,
    output logic [ADDR_W-1:0] cp_addr,
    input  logic              cp_ack,
    output logic              tbl_req,
    output logic [2:0]        tbl_slot,
    input  logic              tbl_ack,
    output logic              eng_req,
    output logic [BLK_W:0]    eng_blocks,
    output logic [ADDR_W-1:0] eng_src_addr,
    input  logic              eng_done,
    input  logic [2:0]        int_mask,
    input  logic [2:0]        int_clr,
    output logic [2:0]        int_status,
    output logic              irq
);
    logic [CMD_W-1:0] head;
    logic             head_valid, pop, drop, done_p, bad_p;
    logic [IRQ_N-1:0] ev;

    cmdq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
        .pop(pop), .head(head), .valid(head_valid),
        .empty(q_empty), .drop(drop)
    );

    cmdq_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WCNT_W(WCNT_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .head_valid(head_valid), .head(head), .pop(pop), .busy(eng_busy),
        .cp_req(cp_req), .cp_dir(cp_dir), .cp_words(cp_words),
        .cp_addr(cp_addr), .cp_ack(cp_ack),
        .tbl_req(tbl_req), .tbl_slot(tbl_slot), .tbl_ack(tbl_ack),
        .eng_req(eng_req), .eng_blocks(eng_blocks),
        .eng_src_addr(eng_src_addr), .eng_done(eng_done),
        .done_p(done_p), .bad_p(bad_p)
    );

    assign dma_busy = cp_req;

    always_comb begin
        ev           = '0;
        ev[IRQ_DONE] = done_p;
        ev[IRQ_BAD]  = bad_p;
        ev[IRQ_OVF]  = drop;
    end

    cmdq_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set(ev), .clr(int_clr), .mask(int_mask),
        .status(int_status), .irq(irq)
    );

    assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> int_status[IRQ_DONE]);
    assert_copy_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_req) |-> (dma_busy && eng_busy));
endmodule

// File: tb/tb_cmdq_seq_top.sv
`timescale 1ns/1ps
module tb_cmdq_seq_top;
    logic        clk = 0, rst_n = 0;
    logic        cmd_wr_en = 0;
    logic [31:0] cmd_wr_data = 0;
    logic        eng_busy, q_empty, dma_busy;
    logic        cp_req, cp_dir, cp_ack = 0;
    logic [12:0] cp_words;
    logic [31:0] cp_addr, eng_src_addr;
    logic        tbl_req, tbl_ack = 0;
    logic [2:0]  tbl_slot;
    logic        eng_req, eng_done = 0;
    logic [12:0] eng_blocks;
    logic [2:0]  int_mask = 3'b111, int_clr = 0, int_status;
    logic        irq;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    cmdq_seq_top dut (.*);

    function automatic logic [31:0] w_copy(input logic dir, input logic [12:0] n);
        return (32'h21 << 26) | (32'(dir) << 25) | (32'(n) << 12);
    endfunction
    function automatic logic [31:0] w_table(input logic [5:0] id);
        return (32'h23 << 26) | (32'h3 << 24) | (32'h1 << 23) | (32'(id) << 17);
    endfunction
    function automatic logic [31:0] w_start(input logic [11:0] f);
        return (32'h0E << 26) | 32'(f);
    endfunction
    function automatic logic [31:0] w_setup();
        return 32'h10 << 26;
    endfunction
    function automatic logic [31:0] w_done();
        return 32'h11 << 26;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cmd_wr_en = 1; cmd_wr_data = w;
        @(negedge clk);
        cmd_wr_en = 0;
    endtask

    task automatic wait_for(input int sel, output bit seen);
        seen = 0;
        for (int i = 0; i < 64 && !seen; i++) begin
            @(negedge clk);
            case (sel)
                0: seen = cp_req;
                1: seen = tbl_req;
                2: seen = eng_req;
                default: seen = int_status[0];
            endcase
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        int_clr = 3'b111;
        @(negedge clk);
        int_clr = 0;
    endtask

    task automatic ack_run();
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(q_empty && !eng_busy && !dma_busy, "R1 idle flags", {eng_busy, q_empty, dma_busy}, 3'b010);
        chk(!cp_req && !tbl_req && !eng_req && int_status == 0 && !irq, "R1 requests/status",
            {cp_req, tbl_req, eng_req, int_status}, 0);

        for (int it = 0; it < 60; it++) begin
            int t = $urandom % 4;
            case (t)
                0: begin // R4 copy
                    logic dir = 1'($urandom);
                    logic [12:0] n = (it % 5 == 0) ? 13'd16 : 13'($urandom);
                    logic [31:0] a = $urandom;
                    int hold = $urandom % 4;
                    wr(w_copy(dir, n)); wr(a);
                    wait_for(0, seen);
                    chk(seen, "R4 cp_req raised", 32'(seen), 1);
                    chk(cp_dir == dir && cp_words == n, "R4 dir/words", {cp_dir, cp_words}, {dir, n});
                    chk(cp_addr == a, "R4 address word", cp_addr, a);
                    chk(dma_busy && eng_busy, "R4 dma_busy R9 eng_busy", {dma_busy, eng_busy}, 2'b11);
                    repeat (hold) @(negedge clk);
                    chk(cp_req && cp_addr == a, "R4 held until ack", cp_addr, a);
                    cp_ack = 1; @(negedge clk); cp_ack = 0;
                    chk(!cp_req && !dma_busy, "R4 released", {cp_req, dma_busy}, 0);
                end
                1: begin // R5 table-load
                    logic [2:0] s = 3'($urandom);
                    wr(w_table({3'b001, s}));
                    wait_for(1, seen);
                    chk(seen && tbl_slot == s, "R5 slot", {29'b0, tbl_slot}, {29'b0, s});
                    tbl_ack = 1; @(negedge clk); tbl_ack = 0;
                    chk(!tbl_req, "R5 released", 32'(tbl_req), 0);
                end
                2: begin // R6 setup, R7 start
                    logic [31:0] a = $urandom;
                    logic [11:0] f = (it % 7 == 0) ? 12'hFFF : 12'($urandom);
                    wr(w_setup()); wr(a); wr(w_start(f));
                    wait_for(2, seen);
                    chk(seen && eng_blocks == {1'b0, f} + 13'd1, "R7 block count", 32'(eng_blocks), 32'(f) + 1);
                    chk(eng_src_addr == a, "R6 source address", eng_src_addr, a);
                    repeat ($urandom % 3) @(negedge clk);
                    chk(eng_req && eng_busy, "R9 busy while run", {eng_req, eng_busy}, 2'b11);
                    ack_run();
                    chk(!eng_req, "R7 released", 32'(eng_req), 0);
                end
                default: begin // R8 done
                    wr(w_done());
                    wait_for(3, seen);
                    chk(seen, "R8 done interrupt", 32'(int_status), 1);
                    chk(irq, "R10 irq on masked cause", 32'(irq), 1);
                    clear_all();
                    chk(int_status == 0, "R10 w1c clears", 32'(int_status), 0);
                end
            endcase
        end

        // R8 done waits behind a running start
        wr(w_start(12'd3)); wr(w_done());
        wait_for(2, seen);
        repeat (3) @(negedge clk);
        chk(int_status[0] == 0, "R8 done held back by R9", 32'(int_status), 0);
        ack_run();
        wait_for(3, seen);
        chk(seen, "R8 done after run", 32'(int_status), 1);
        clear_all();

        // R2 fill queue behind a held run, then overflow
        wr(w_start(12'd0));
        wait_for(2, seen);
        for (int k = 1; k <= 5; k++) wr(w_start(12'(k)));
        chk(int_status[2] == 0 && !q_empty, "R2 five words fit", 32'(int_status), 0);
        wr(w_start(12'd9));
        chk(int_status[2] == 1, "R2 overflow flag", 32'(int_status), 4);
        ack_run();
        for (int k = 1; k <= 5; k++) begin
            wait_for(2, seen);
            chk(seen && eng_blocks == 13'(k + 1), "R2 order", 32'(eng_blocks), k + 1);
            ack_run();
        end
        wait_for(2, seen);
        chk(!seen && q_empty && !eng_busy, "R2 dropped word absent", 32'(seen), 0);

        // R10 mask
        int_mask = 3'b000;
        @(negedge clk);
        chk(!irq && int_status[2], "R10 masked irq low", 32'(irq), 0);
        int_mask = 3'b100;
        @(negedge clk);
        chk(irq, "R10 unmasked irq", 32'(irq), 1);
        int_mask = 3'b111;
        // R10 set wins over clear
        @(negedge clk);
        int_clr = 3'b010; cmd_wr_en = 1; cmd_wr_data = 32'hFC00_0000;
        @(negedge clk);
        cmd_wr_en = 0; int_clr = 0;
        clear_all();

        // R3 unknown opcode
        wr(32'hFC00_1234);
        repeat (3) @(negedge clk);
        chk(int_status == 3'b010, "R3 bad opcode flag", 32'(int_status), 2);
        chk(!cp_req && !tbl_req && !eng_req && q_empty && !eng_busy, "R3 discarded",
            {cp_req, tbl_req, eng_req, q_empty}, 1);
        clear_all();
        chk(int_status == 0, "R10 bad flag cleared", 32'(int_status), 0);
        // R3/R5 malformed table id
        wr(w_table(6'b000_101));
        repeat (3) @(negedge clk);
        chk(int_status == 3'b010 && !tbl_req, "R5 malformed table rejected", 32'(int_status), 2);
        clear_all();
        // R5 wrong RAM select
        wr(w_table(6'b001_010) & ~(32'h1 << 23));
        repeat (3) @(negedge clk);
        chk(int_status == 3'b010 && !tbl_req, "R5 ram select checked", 32'(int_status), 2);
        clear_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule